// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers four interrupt causes into one status byte. A host can then tell with a single read whether this device raised the interrupt. Three causes are event-type and are captured on their rising edge: a bus clock failure, a frame boundary and an internal master PLL error. Each stays pending until the host writes a one to its bit. The fourth cause is a live summary of detailed bus error flags. These flags arrive in three groups, and the summary bit is high while any flag in any group is high.

Each cause has its own mask bit, and a set mask bit blocks that cause from the request line. The active-low request output is registered. It drops on the clock after an unmasked cause becomes pending. At reset every cause starts masked and no status is held.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, `status_o` reads 0 when all group flags are low, `mask_o` reads all ones (4'hF) and `irq_n_o` is high.
- R2: A rising edge on `clk_fail_i`, `frame_i` or `pll_err_i` seen at a clock edge sets `status_o` bit 0, 1 or 2 respectively, visible after that edge; a level held high does not set the bit again once cleared.
- R3: With `st_wr_i` high, each one in `st_wdata_i[2:0]` clears the matching latched bit at the clock edge; bits written with zero keep their value.
- R4: If a rising edge and a write-one clear hit the same latched bit in the same cycle, the bit ends up set.
- R5: `status_o` bit 3 is high, without delay, exactly when any bit of `err_grp_a_i`, `err_grp_b_i` or `err_grp_c_i` is high; writes to bit 3 have no effect on it.
- R6: `status_o` bits 7 down to 4 always read zero.
- R7: `mask_o` loads `msk_wdata_i` at a clock edge with `msk_wr_i` high; mask bit i set to 1 blocks status bit i, so `irq_n_o` stays high while every pending bit is masked.
- R8: `irq_n_o` at each clock edge becomes the inverse of the OR over status bits 3..0 ANDed with the inverted mask, both taken just before that edge, so it falls one clock after an unmasked cause becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_fail_i | input | 1 | Bus clock failure event |
| frame_i | input | 1 | Frame boundary event |
| pll_err_i | input | 1 | Internal master PLL error event |
| err_grp_a_i | input | GRP_A_W (4) | First group of detailed bus error flags |
| err_grp_b_i | input | GRP_B_W (3) | Second group of detailed bus error flags |
| err_grp_c_i | input | GRP_C_W (4) | Third group of detailed bus error flags |
| st_wr_i | input | 1 | Status write strobe (write one to clear) |
| st_wdata_i | input | STAT_W (8) | Status write data |
| msk_wr_i | input | 1 | Mask write strobe |
| msk_wdata_i | input | 4 | New mask value, bit i masks status bit i |
| status_o | output | STAT_W (8) | Status byte read value |
| mask_o | output | 4 | Current mask value |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default values: error groups of 4, 3 and 4 flags and an 8-bit status byte. With these values every group flag can be raised alone to test the summary, and the four always-zero upper bits can be observed. A random phase toggles events, writes and masks on each cycle, which reaches coincident set and clear, masked-only pending and changes to the mask in the same cycle as a new event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int N_SRC  = 4;
   localparam int N_EDGE = 3;

   typedef enum int unsigned {
      SRC_CLKFAIL = 0,
      SRC_FRAME   = 1,
      SRC_PLLERR  = 2,
      SRC_BUSERR  = 3
   } src_idx_e;

   typedef logic [N_SRC-1:0]  src_vec_t;
   typedef logic [N_EDGE-1:0] edge_vec_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   if (N < 1) begin : g_bad_n
      $error("irq_edge_latch: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      logic stat_q;
      logic rise;

      assign rise = lvl_i[i] & ~prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            prev_q <= lvl_i[i];
            // a new edge takes priority over a coincident clear
            stat_q <= rise | (stat_q & ~clr_i[i]);
         end
      end

      assign stat_o[i] = stat_q;
   end
endmodule

// File: rtl/irq_err_summary.sv
module irq_err_summary #(
   parameter int GRP_A_W = 4,
   parameter int GRP_B_W = 3,
   parameter int GRP_C_W = 4
) (
   input  logic [GRP_A_W-1:0] grp_a_i,
   input  logic [GRP_B_W-1:0] grp_b_i,
   input  logic [GRP_C_W-1:0] grp_c_i,
   output logic               any_o
);
   localparam int TOT_W = GRP_A_W + GRP_B_W + GRP_C_W;

   if (GRP_A_W < 1 || GRP_B_W < 1 || GRP_C_W < 1) begin : g_bad_w
      $error("irq_err_summary: every group needs at least one flag");
   end

   logic [TOT_W-1:0] all_flags;
   assign all_flags = {grp_c_i, grp_b_i, grp_a_i};
   assign any_o     = |all_flags;
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
   import irq_agg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t pend_i,
   input  logic     msk_wr_i,
   input  src_vec_t msk_wdata_i,
   output src_vec_t mask_o,
   output logic     irq_n_o
);
   src_vec_t mask_q;
   logic     irq_n_q;
   logic     req;

   assign req = |(pend_i & ~mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         irq_n_q <= 1'b1;
      end else begin
         irq_n_q <= ~req;
         if (msk_wr_i) mask_q <= msk_wdata_i;
      end
   end

   assign mask_o  = mask_q;
   assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int GRP_A_W = 4,
   parameter int GRP_B_W = 3,
   parameter int GRP_C_W = 4,
   parameter int STAT_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_fail_i,
   input  logic               frame_i,
   input  logic               pll_err_i,
   input  logic [GRP_A_W-1:0] err_grp_a_i,
   input  logic [GRP_B_W-1:0] err_grp_b_i,
   input  logic [GRP_C_W-1:0] err_grp_c_i,
   input  logic               st_wr_i,
   input  logic [STAT_W-1:0]  st_wdata_i,
   input  logic               msk_wr_i,
   input  logic [N_SRC-1:0]   msk_wdata_i,
   output logic [STAT_W-1:0]  status_o,
   output logic [N_SRC-1:0]   mask_o,
   output logic               irq_n_o
);
   localparam int PAD_W = STAT_W - N_SRC;

   if (STAT_W <= N_SRC) begin : g_bad_stat
      $error("irq_status_agg: STAT_W must exceed the source count");
   end

   edge_vec_t edge_lvl;
   edge_vec_t edge_clr;
   edge_vec_t edge_stat;
   logic      bus_err_any;
   src_vec_t  pend;

   assign edge_lvl[SRC_CLKFAIL] = clk_fail_i;
   assign edge_lvl[SRC_FRAME]   = frame_i;
   assign edge_lvl[SRC_PLLERR]  = pll_err_i;
   assign edge_clr = st_wr_i ? st_wdata_i[N_EDGE-1:0] : '0;

   irq_edge_latch #(.N(N_EDGE)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (edge_lvl),
      .clr_i  (edge_clr),
      .stat_o (edge_stat)
   );

   irq_err_summary #(
      .GRP_A_W (GRP_A_W),
      .GRP_B_W (GRP_B_W),
      .GRP_C_W (GRP_C_W)
   ) u_sum (
      .grp_a_i (err_grp_a_i),
      .grp_b_i (err_grp_b_i),
      .grp_c_i (err_grp_c_i),
      .any_o   (bus_err_any)
   );

   assign pend = {bus_err_any, edge_stat};

   irq_mask_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_i      (pend),
      .msk_wr_i    (msk_wr_i),
      .msk_wdata_i (msk_wdata_i),
      .mask_o      (mask_o),
      .irq_n_o     (irq_n_o)
   );

   assign status_o = {{PAD_W{1'b0}}, pend};
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
   parameter int GRP_A_W = 4,
   parameter int GRP_B_W = 3,
   parameter int GRP_C_W = 4,
   parameter int STAT_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clk_fail_i,
   input logic               frame_i,
   input logic               pll_err_i,
   input logic [GRP_A_W-1:0] err_grp_a_i,
   input logic [GRP_B_W-1:0] err_grp_b_i,
   input logic [GRP_C_W-1:0] err_grp_c_i,
   input logic               st_wr_i,
   input logic [STAT_W-1:0]  st_wdata_i,
   input logic [3:0]         mask_o,
   input logic [STAT_W-1:0]  status_o,
   input logic               irq_n_o
);
   logic [2:0] src;
   logic [2:0] src_d;
   logic [2:0] rise;

   assign src  = {pll_err_i, frame_i, clk_fail_i};
   assign rise = src & ~src_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_d <= 3'b0;
      else        src_d <= src;
   end

   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((status_o[2:0] & $past(rise)) == $past(rise)));

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_i && |(st_wdata_i[2:0] & ~rise))
      |=> ((status_o[2:0] & $past(st_wdata_i[2:0] & ~rise)) == 3'b0));

   p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[3] == ((|err_grp_a_i) | (|err_grp_b_i) | (|err_grp_c_i)));

   p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[STAT_W-1:4] == '0);

   p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_o) |=> irq_n_o);

   p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n_o == !$past(|(status_o[3:0] & ~mask_o))));
endmodule

bind irq_status_agg irq_status_agg_chk #(
   .GRP_A_W (GRP_A_W),
   .GRP_B_W (GRP_B_W),
   .GRP_C_W (GRP_C_W),
   .STAT_W  (STAT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clk_fail_i  (clk_fail_i),
   .frame_i     (frame_i),
   .pll_err_i   (pll_err_i),
   .err_grp_a_i (err_grp_a_i),
   .err_grp_b_i (err_grp_b_i),
   .err_grp_c_i (err_grp_c_i),
   .st_wr_i     (st_wr_i),
   .st_wdata_i  (st_wdata_i),
   .mask_o      (mask_o),
   .status_o    (status_o),
   .irq_n_o     (irq_n_o)
);

// File: tb/irq_status_agg_tb.sv
`timescale 1ns/1ps
module irq_status_agg_tb;
   localparam int GA = 4;
   localparam int GB = 3;
   localparam int GC = 4;
   localparam int SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_fail_i = 1'b0, frame_i = 1'b0, pll_err_i = 1'b0;
   logic [GA-1:0] ga = '0;
   logic [GB-1:0] gb = '0;
   logic [GC-1:0] gc = '0;
   logic          st_wr_i = 1'b0;
   logic [SW-1:0] st_wdata_i = '0;
   logic          msk_wr_i = 1'b0;
   logic [3:0]    msk_wdata_i = '0;
   logic [SW-1:0] status_o;
   logic [3:0]    mask_o;
   logic          irq_n_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_status_agg #(.GRP_A_W(GA), .GRP_B_W(GB), .GRP_C_W(GC), .STAT_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .clk_fail_i(clk_fail_i), .frame_i(frame_i), .pll_err_i(pll_err_i),
      .err_grp_a_i(ga), .err_grp_b_i(gb), .err_grp_c_i(gc),
      .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
      .msk_wr_i(msk_wr_i), .msk_wdata_i(msk_wdata_i),
      .status_o(status_o), .mask_o(mask_o), .irq_n_o(irq_n_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, updated on every edge
   bit [2:0] m_stat;
   bit [2:0] m_prev;
   bit [3:0] m_mask;
   bit       m_irq_n;

   function automatic bit sum_now();
      return (ga != 0) || (gb != 0) || (gc != 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_stat = 0; m_prev = 0; m_mask = 4'hF; m_irq_n = 1;
      end else begin
         bit [2:0] now;
         bit [2:0] clr;
         now = {pll_err_i, frame_i, clk_fail_i};
         clr = st_wr_i ? st_wdata_i[2:0] : 3'b0;
         m_irq_n = !(|({sum_now(), m_stat} & ~m_mask));
         m_stat = (m_stat & ~clr) | (now & ~m_prev);
         m_prev = now;
         if (msk_wr_i) m_mask = msk_wdata_i;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(status_o[2:0] == m_stat, "R2/R3 latched bits", status_o[2:0], m_stat);
         chk(status_o[3] == sum_now(), "R5 summary bit", status_o[3], sum_now());
         chk(status_o[7:4] == 4'h0, "R6 upper bits", status_o[7:4], 0);
         chk(mask_o == m_mask, "R7 mask readback", mask_o, m_mask);
         chk(irq_n_o == m_irq_n, "R8 irq_n", irq_n_o, m_irq_n);
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic idle_strobes();
      st_wr_i = 0; st_wdata_i = '0; msk_wr_i = 0;
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk(status_o == 8'h00, "R1 status after reset", status_o, 0);
      chk(mask_o == 4'hF, "R1 mask after reset", mask_o, 4'hF);
      chk(irq_n_o == 1'b1, "R1 irq_n after reset", irq_n_o, 1);

      // R2 clock-fail pulse, R7 still masked
      clk_fail_i = 1; tick(); clk_fail_i = 0; tick();
      chk(status_o[0] == 1'b1, "R2 clk fail latched", status_o[0], 1);
      tick();
      chk(irq_n_o == 1'b1, "R7 masked pending keeps irq high", irq_n_o, 1);

      // R8 unmask: irq falls one clock after the mask write lands
      msk_wr_i = 1; msk_wdata_i = 4'h0; tick(); idle_strobes();
      chk(irq_n_o == 1'b1, "R8 irq not yet low", irq_n_o, 1);
      tick();
      chk(irq_n_o == 1'b0, "R8 irq low", irq_n_o, 0);

      // R3 write one to clear bit 0; zero written to others keeps them
      frame_i = 1; tick();
      st_wr_i = 1; st_wdata_i = 8'h01; tick(); idle_strobes();
      chk(status_o[1:0] == 2'b10, "R3 clear bit0 keep bit1", status_o[1:0], 2'b10);
      // held high frame does not re-set after clear (R2)
      st_wr_i = 1; st_wdata_i = 8'h02; tick(); idle_strobes();
      tick(); tick();
      chk(status_o[1] == 1'b0, "R2 held level no re-set", status_o[1], 0);
      frame_i = 0;

      // R4 set beats clear
      pll_err_i = 1; st_wr_i = 1; st_wdata_i = 8'h04; tick(); idle_strobes();
      chk(status_o[2] == 1'b1, "R4 set wins over clear", status_o[2], 1);
      pll_err_i = 0;
      st_wr_i = 1; st_wdata_i = 8'h07; tick(); idle_strobes();
      chk(status_o[2:0] == 3'b000, "R3 clear all latched", status_o[2:0], 0);

      // R5 each group flag alone, write to bit 3 has no effect
      for (int i = 0; i < GA + GB + GC; i++) begin
         {gc, gb, ga} = (GA + GB + GC)'(1) << i;
         st_wr_i = 1; st_wdata_i = 8'hF8; tick(); idle_strobes();
         chk(status_o[3] == 1'b1, "R5 single flag sets summary", status_o[3], 1);
      end
      // R7 mask only bit 3 with summary active
      msk_wr_i = 1; msk_wdata_i = 4'h8; tick(); idle_strobes(); tick();
      chk(irq_n_o == 1'b1, "R7 summary masked", irq_n_o, 1);
      {gc, gb, ga} = '0; tick();
      chk(status_o[3] == 1'b0, "R5 summary clears with flags", status_o[3], 0);

      // random phase, reference model checks every cycle
      for (int k = 0; k < 2000; k++) begin
         clk_fail_i = ($urandom % 4) == 0;
         frame_i    = ($urandom % 3) == 0;
         pll_err_i  = ($urandom % 5) == 0;
         ga = (($urandom % 6) == 0) ? GA'($urandom) : '0;
         gb = (($urandom % 8) == 0) ? GB'($urandom) : '0;
         gc = (($urandom % 8) == 0) ? GC'($urandom) : '0;
         st_wr_i = ($urandom % 3) == 0; st_wdata_i = SW'($urandom);
         msk_wr_i = ($urandom % 7) == 0; msk_wdata_i = 4'($urandom);
         tick();
      end
      idle_strobes();
      tick();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule